// File: doc/BRIEF.md
# Packed-SIMD Unsigned Divider Array

This block divides one 64-bit packed word by another. A two-bit mode chooses how the word is cut into lanes: one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Each lane is an independent unsigned division, and the packed quotient and remainder come back in the same byte positions as the operands.

Inside there are eight sequential radix-2 divider units of unequal width: one 64-bit unit (A), one 32-bit unit (B), two 16-bit units (C, D) and four 8-bit units (E to H). Every mode runs its most significant lane on unit A. The next units take the remaining lanes in a fixed pattern, so the wide units are reused and there is no full set of units for every width. A narrow lane placed on a wide unit has its upper operand bits filled with zeros, and only the low lane-width bits of that unit's result are kept.

A caller pulses `start_i` while the block is idle. It then waits for the one-cycle `done_o` pulse and reads the results, which stay stable until the next accepted start. The byte width is a parameter. The lane layout is fixed at eight bytes per word.

Top module: `simd_div_array`

## Requirements
- R1: With mode_i = 0, the 64-bit dividend is divided by the 64-bit divisor. quotient_o and remainder_o hold the full 64-bit quotient and remainder.
- R2: With mode_i = 1, bytes 7..4 and bytes 3..0 are two separate unsigned 32-bit divisions. Each result is returned in the bytes of its own lane.
- R3: With mode_i = 2, each byte pair (7..6, 5..4, 3..2, 1..0) is a separate unsigned 16-bit division. Each result is returned in the bytes of its own pair.
- R4: With mode_i = 3, each of the eight bytes is a separate unsigned 8-bit division. Each result is returned in its own byte.
- R5: A lane whose divisor is zero gets an all-ones quotient and its own dividend as remainder. The other lanes in the same word are not affected.
- R6: A start seen while idle makes busy_o high on the next cycle. done_o is high for exactly one cycle, and busy_o is low in that cycle.
- R7: While the block is idle and start_i is low, quotient_o and remainder_o do not change, even if the mode and operand inputs do.
- R8: A start pulse, mode change or operand change while busy_o is high is ignored. The current operation completes with the values captured at its accepted start.
- R9: In every mode, done_o rises exactly 8*BYTE_W+1 clock edges after the edge that accepted the start. This is 65 edges with the default byte width.
- R10: During and right after reset, busy_o and done_o are low and quotient_o and remainder_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| mode_i | input | 2 | Lane split: 0 = 64-bit, 1 = 32-bit, 2 = 16-bit, 3 = 8-bit |
| dividend_i | input | 8*BYTE_W | Packed dividends |
| divisor_i | input | 8*BYTE_W | Packed divisors |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when every lane has finished |
| quotient_o | output | 8*BYTE_W | Packed quotients |
| remainder_o | output | 8*BYTE_W | Packed remainders |

## Verification
The bench runs every mode with operands whose upper lanes hold large values next to small or zero lanes. If the byte steering or the lane masking were wrong, a neighbouring lane's bits would end up in a result, or a narrow lane placed on unit A or B would keep bits from above its own width. Zero-divisor lanes are mixed with normal lanes in the same word, so a divider that spread its zero handling across the word, or gave a zero quotient, would produce wrong bytes. The bench also starts a new operation in the middle of a run and changes the mode and operands while idle. A design that restarted on the extra start, or that decoded results with the live mode instead of the captured one, would return different values or take a different number of cycles.

// File: rtl/simd_div_pkg.sv
package simd_div_pkg;

   typedef enum logic [1:0] {
      SD_W64 = 2'd0,
      SD_W32 = 2'd1,
      SD_W16 = 2'd2,
      SD_W8  = 2'd3
   } sd_mode_e;

   // unit index: 0=A(64) 1=B(32) 2=C(16) 3=D(16) 4..7=E..H(8)
   localparam int SD_UNITS      = 8;
   localparam int SD_WORD_BYTES = 8;

   function automatic int sd_unit_bytes(input int u);
      case (u)
         0:       return 8;
         1:       return 4;
         2, 3:    return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int sd_lane_bytes(input sd_mode_e m);
      case (m)
         SD_W64:  return 8;
         SD_W32:  return 4;
         SD_W16:  return 2;
         default: return 1;
      endcase
   endfunction

   function automatic logic sd_unit_used(input int u, input sd_mode_e m);
      case (u)
         0:       return 1'b1;
         1:       return (m != SD_W64);
         2, 3:    return (m == SD_W16) || (m == SD_W8);
         default: return (m == SD_W8);
      endcase
   endfunction

   // byte offset of the lane a unit serves; the top lane always sits on A
   function automatic int sd_lane_off(input int u, input sd_mode_e m);
      int off;
      off = 0;
      case (u)
         0: case (m)
               SD_W64:  off = 0;
               SD_W32:  off = 4;
               SD_W16:  off = 6;
               default: off = 7;
            endcase
         1: case (m)
               SD_W16:  off = 2;
               SD_W8:   off = 3;
               default: off = 0;
            endcase
         2: off = (m == SD_W8) ? 5 : 4;
         3: off = (m == SD_W8) ? 1 : 0;
         4: off = 6;
         5: off = 4;
         6: off = 2;
         default: off = 0;
      endcase
      return off;
   endfunction

   function automatic logic [SD_UNITS-1:0] sd_used_mask(input sd_mode_e m);
      logic [SD_UNITS-1:0] v;
      for (int u = 0; u < SD_UNITS; u++) v[u] = sd_unit_used(u, m);
      return v;
   endfunction

endpackage

// File: rtl/simd_div_unit.sv
module simd_div_unit #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] dvs_i,
   output logic         done_o,
   output logic [W-1:0] quot_o,
   output logic [W-1:0] rem_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  q_r, r_r, d_r;
   logic [CW-1:0] cnt_r;
   logic          run_r, done_r;
   logic [W:0]    shifted, diff;
   logic          fits;

   always_comb begin
      shifted = {r_r, q_r[W-1]};
      diff    = shifted - {1'b0, d_r};
      fits    = (shifted >= {1'b0, d_r});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r    <= '0;
         r_r    <= '0;
         d_r    <= '0;
         cnt_r  <= '0;
         run_r  <= 1'b0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (start_i && !run_r) begin
            q_r   <= dvd_i;
            d_r   <= dvs_i;
            r_r   <= '0;
            cnt_r <= CW'(W);
            run_r <= 1'b1;
         end else if (run_r) begin
            r_r   <= fits ? diff[W-1:0] : shifted[W-1:0];
            q_r   <= {q_r[W-2:0], fits};
            cnt_r <= cnt_r - CW'(1);
            if (cnt_r == CW'(1)) begin
               run_r  <= 1'b0;
               done_r <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_r;
   assign quot_o = q_r;
   assign rem_o  = r_r;

endmodule

// File: rtl/simd_div_pick.sv
module simd_div_pick
   import simd_div_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int UNIT   = 0,
   localparam int WORD_W = SD_WORD_BYTES * BYTE_W,
   localparam int UW     = sd_unit_bytes(UNIT) * BYTE_W
) (
   input  sd_mode_e          mode_i,
   input  logic [WORD_W-1:0] dvd_i,
   input  logic [WORD_W-1:0] dvs_i,
   output logic [UW-1:0]     dvd_o,
   output logic [UW-1:0]     dvs_o
);
   int          sh, lb;
   logic [UW-1:0] m;

   always_comb begin
      sh = sd_lane_off(UNIT, mode_i) * BYTE_W;
      lb = sd_lane_bytes(mode_i) * BYTE_W;
      if (lb >= UW) m = '1;
      else          m = (UW'(1) << lb) - UW'(1);
      if (sd_unit_used(UNIT, mode_i)) begin
         dvd_o = UW'(dvd_i >> sh) & m;
         dvs_o = UW'(dvs_i >> sh) & m;
      end else begin
         dvd_o = '0;
         dvs_o = '0;
      end
   end

endmodule

// File: rtl/simd_div_gather.sv
module simd_div_gather
   import simd_div_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = SD_WORD_BYTES * BYTE_W
) (
   input  sd_mode_e                          mode_i,
   input  logic [SD_UNITS-1:0][WORD_W-1:0]   uq_i,
   input  logic [SD_UNITS-1:0][WORD_W-1:0]   ur_i,
   output logic [WORD_W-1:0]                 quot_o,
   output logic [WORD_W-1:0]                 rem_o
);
   int            lb;
   logic [WORD_W-1:0] m;

   always_comb begin
      lb = sd_lane_bytes(mode_i) * BYTE_W;
      if (lb >= WORD_W) m = '1;
      else              m = (WORD_W'(1) << lb) - WORD_W'(1);
      quot_o = '0;
      rem_o  = '0;
      for (int u = 0; u < SD_UNITS; u++) begin
         if (sd_unit_used(u, mode_i)) begin
            quot_o = quot_o | ((uq_i[u] & m) << (sd_lane_off(u, mode_i) * BYTE_W));
            rem_o  = rem_o  | ((ur_i[u] & m) << (sd_lane_off(u, mode_i) * BYTE_W));
         end
      end
   end

endmodule

// File: rtl/simd_div_array.sv
module simd_div_array
   import simd_div_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = SD_WORD_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [WORD_W-1:0] dividend_i,
   input  logic [WORD_W-1:0] divisor_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [WORD_W-1:0] quotient_o,
   output logic [WORD_W-1:0] remainder_o
);
   // elaboration-time checks
   if (BYTE_W < 2) begin : g_bad_byte
      $error("simd_div_array: BYTE_W must be at least 2");
   end
   for (genvar gu = 0; gu < SD_UNITS; gu++) begin : g_fit
      for (genvar gm = 0; gm < 4; gm++) begin : g_mode
         if (sd_unit_used(gu, sd_mode_e'(gm)) &&
             sd_lane_bytes(sd_mode_e'(gm)) > sd_unit_bytes(gu)) begin : g_bad
            $error("simd_div_array: lane wider than its unit");
         end
      end
   end

   sd_mode_e                        mode_in, mode_q;
   logic [SD_UNITS-1:0]             used_in, pend_q, u_done, u_start, pend_left;
   logic [SD_UNITS-1:0][WORD_W-1:0] u_q, u_r;
   logic                            busy_q, done_q, accept;

   assign mode_in = sd_mode_e'(mode_i);
   assign used_in = sd_used_mask(mode_in);
   assign accept  = start_i && !busy_q;
   assign u_start = accept ? used_in : '0;

   for (genvar g = 0; g < SD_UNITS; g++) begin : g_unit
      localparam int UW = sd_unit_bytes(g) * BYTE_W;
      logic [UW-1:0] op_a, op_b, q_n, r_n;

      simd_div_pick #(.BYTE_W(BYTE_W), .UNIT(g)) u_pick (
         .mode_i (mode_in),
         .dvd_i  (dividend_i),
         .dvs_i  (divisor_i),
         .dvd_o  (op_a),
         .dvs_o  (op_b)
      );

      simd_div_unit #(.W(UW)) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (u_start[g]),
         .dvd_i   (op_a),
         .dvs_i   (op_b),
         .done_o  (u_done[g]),
         .quot_o  (q_n),
         .rem_o   (r_n)
      );

      assign u_q[g] = WORD_W'(q_n);
      assign u_r[g] = WORD_W'(r_n);
   end

   assign pend_left = pend_q & ~u_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pend_q <= '0;
         mode_q <= SD_W64;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            mode_q <= mode_in;
            pend_q <= used_in;
         end else if (busy_q) begin
            pend_q <= pend_left;
            if (pend_left == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   simd_div_gather #(.BYTE_W(BYTE_W)) u_gather (
      .mode_i (mode_q),
      .uq_i   (u_q),
      .ur_i   (u_r),
      .quot_o (quotient_o),
      .rem_o  (remainder_o)
   );

   assign busy_o = busy_q;
   assign done_o = done_q;

endmodule

// File: rtl/simd_div_array_chk.sv
module simd_div_array_chk #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 8 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [1:0]        mode_i,
   input logic [WORD_W-1:0] dividend_i,
   input logic [WORD_W-1:0] divisor_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [WORD_W-1:0] quotient_o,
   input logic [WORD_W-1:0] remainder_o
);
   int lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 lat_q <= 0;
      else if (start_i && !busy_o) lat_q <= 0;
      else if (busy_o)            lat_q <= lat_q + 1;
   end

   p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == WORD_W + 1));

   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

endmodule

bind simd_div_array simd_div_array_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/simd_div_array_bench.sv
`timescale 1ns/1ps
module simd_div_array_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [1:0]  mode;
   logic [63:0] dvd, dvs;
   logic        busy, done;
   logic [63:0] quot, rem;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   simd_div_array u_simd_div_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .mode_i      (mode),
      .dividend_i  (dvd),
      .divisor_i   (dvs),
      .busy_o      (busy),
      .done_o      (done),
      .quotient_o  (quot),
      .remainder_o (rem)
   );

   // {mode, dividend, divisor}
   localparam logic [129:0] VEC [0:7] = '{
      {2'd0, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_1234_5678},
      {2'd0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0000},
      {2'd0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007},
      {2'd1, 64'hFFFF_FFFF_0000_03E8, 64'h0000_0003_0000_0007},
      {2'd1, 64'h0000_000A_DEAD_BEEF, 64'h0000_0000_0000_0100},
      {2'd2, 64'h1234_FFFF_0100_8000, 64'h0011_0000_0003_00FF},
      {2'd3, 64'hFF80_7F01_00FE_1064, 64'h0F02_0000_FF01_0307},
      {2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0408_1020_4080}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b,
                                 output logic [63:0] q, output logic [63:0] r, output bit hasz);
      int lbits;
      logic [63:0] msk, av, bv;
      lbits = 64 >> m;
      msk = (lbits == 64) ? '1 : ((64'd1 << lbits) - 64'd1);
      q = '0; r = '0; hasz = 0;
      for (int l = 0; l < 64 / lbits; l++) begin
         av = (a >> (l * lbits)) & msk;
         bv = (b >> (l * lbits)) & msk;
         if (bv == 0) begin
            hasz = 1;
            q = q | (msk << (l * lbits));
            r = r | (av << (l * lbits));
         end else begin
            q = q | ((av / bv) << (l * lbits));
            r = r | ((av % bv) << (l * lbits));
         end
      end
   endfunction

   function automatic string mtag(input logic [1:0] m, input bit hasz);
      if (hasz) return "R5";
      case (m)
         2'd0:    return "R1";
         2'd1:    return "R2";
         2'd2:    return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic run_op(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b, input bit disturb);
      logic [63:0] eq, er;
      bit hz;
      int n;
      string t;
      model(m, a, b, eq, er, hz);
      t = disturb ? "R8" : mtag(m, hz);
      @(negedge clk);
      start = 1'b1; mode = m; dvd = a; dvs = b;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R6 busy after start", 64'(busy), 64'd1);
      n = 0;
      while (!done && n < 1000) begin
         @(negedge clk);
         n++;
         if (disturb && n == 10) begin
            start = 1'b1; mode = ~m; dvd = ~a; dvs = b + 64'd1;
         end
         if (disturb && n == 11) start = 1'b0;
      end
      chk(n == 65, "R9 latency", 64'(n), 64'd65);
      chk(busy == 1'b0, "R6 busy low with done", 64'(busy), 64'd0);
      chk(quot == eq, {t, " quotient"}, quot, eq);
      chk(rem == er, {t, " remainder"}, rem, er);
      @(negedge clk);
      chk(done == 1'b0, "R6 done single cycle", 64'(done), 64'd0);
   endtask

   initial begin
      #750000;
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] q0, r0;
      bit hz;
      rst_n = 1'b0; start = 1'b0; mode = 2'd0; dvd = '0; dvs = '0;
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0, "R10 reset flags", {62'd0, busy, done}, 64'd0);
      chk(quot == 0 && rem == 0, "R10 reset results", quot | rem, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && quot == 0, "R10 after reset", quot, 64'd0);

      for (int i = 0; i < 8; i++)
         run_op(VEC[i][129:128], VEC[i][127:64], VEC[i][63:0], 1'b0);

      // R7: idle outputs unaffected by input changes without start
      model(2'd3, VEC[7][127:64], VEC[7][63:0], q0, r0, hz);
      mode = 2'd0; dvd = 64'h1111_2222_3333_4444; dvs = 64'd9;
      repeat (4) @(negedge clk);
      chk(quot == q0, "R7 quotient held", quot, q0);
      chk(rem == r0, "R7 remainder held", rem, r0);

      // R8: disturbances during busy
      run_op(2'd1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0010_0000_0002, 1'b1);
      run_op(2'd2, 64'hFFFF_0000_ABCD_0042, 64'h0100_0000_0010_0005, 1'b1);

      // R5: isolated zero lane among full 8-bit lanes
      run_op(2'd3, 64'h00FF_FF10_2030_4050, 64'h0101_0002_0304_0500, 1'b0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule